// File: doc/BRIEF.md
# I2C Slave with Indirect Register Select

This block is the serial front end of a small device that holds two byte-wide target registers: a volatile control register and a non-volatile data register. It watches an oversampled I2C bus (SCL and SDA brought in as plain inputs, with SDA driven through an output-enable for open-drain use). It recognises START and STOP conditions and answers only to its own address, which is a fixed device-type field combined with two strap pins. Register traffic is indirect. A write-only access register picks which target later transfers reach. Writes then stream bytes into that target, and reads stream its value back out.

The storage itself sits outside the block. Each accepted write byte leaves on a one-cycle valid/ready strobe tagged with its target. For reads, the current value of each target arrives on a parallel input. The write strobe is the one place where the far side can push back. `wr_valid` is raised for exactly one clock at the eighth SCL rising edge of a data byte. The byte is transferred only if `wr_ready` is high in that same cycle. If `wr_ready` is low, the byte is refused on the bus with a not-acknowledge. It is not offered again, and the rest of that transfer is ignored.

Top module: `i2c_regsel_slave`

## Requirements
- R1: After reset SDA is released (`sda_oe`=0), `wr_valid` is 0, and the selection points at the control register, so a read returns `ctl_rd_i`.
- R2: An address byte whose bits 7:3 equal 01010b and whose bits 2:1 equal `strap_i[1:0]` is acknowledged by pulling SDA low during the ninth SCL clock. Bit 0 of that byte selects the direction: 1 is read and 0 is write.
- R3: An address byte that does not match gets no acknowledge. Every later byte up to the next START is then ignored: it gets no acknowledge and causes no write strobe.
- R4: A START or repeated START, even in the middle of a byte, restarts reception at the address byte. A STOP returns the block to idle.
- R5: In a write, the byte after the address is a register address. 02h names the access register and 00h names the selected target. Any other value is not acknowledged.
- R6: The byte after register address 02h is a select code. 80h selects the control register and 00h selects the data register, and both are acknowledged. Any other code is not acknowledged and leaves the selection unchanged. A byte after the select code is not acknowledged.
- R7: Each byte after register address 00h raises `wr_valid` for one clock with `wr_target` (0 = control, 1 = data) and `wr_data`. If `wr_ready` is high in that cycle, the byte is acknowledged. Otherwise it is not acknowledged and the rest of the transfer is ignored.
- R8: A read shifts out the selected target register, MSB first, and never the access register's contents. It keeps sending while the master acknowledges each byte. After a master not-acknowledge, SDA is released and the bus is ignored until the next START.
- R9: Bits are sampled on SCL rising edges. SDA is only pulled low while SCL is low, so the slave never pulls SDA low while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_o | output | 1 | SDA output value, tied low (open-drain) |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Address strap pins compared with address bits 2:1 |
| wr_valid | output | 1 | One-cycle write strobe toward the target registers |
| wr_ready | input | 1 | Target accepts the strobed byte this cycle |
| wr_target | output | 1 | 0 = control register, 1 = data register |
| wr_data | output | 8 | Byte to be written |
| ctl_rd_i | input | 8 | Current value of the control register |
| nv_rd_i | input | 8 | Current value of the data register |

## Verification
The bench aims at the places where the phase machine can lose its place. These are restarts in the middle of a byte, a STOP right after the address, and the byte that follows a refused one. A design that failed to clear its bit counter on a restart would acknowledge in the wrong slot and misread the address. A design that failed to ignore the bus after a refusal would strobe later bytes into a register.

Select codes outside the two legal values are sent to check that the selection does not move. Reads are issued right after the access register has been addressed, so a design that leaked that register would return 80h or 00h instead of the target. Random write, read and foreign-address transfers, with `wr_ready` dropping now and then, check that strobes reach the right target and that reads continue while the master acknowledges.

// File: rtl/i2crs_pkg.sv
package i2crs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);

  localparam logic [4:0]        DEV_TYPE = 5'b01010;
  localparam logic [BYTE_W-1:0] AR_ADDR  = 8'h02;
  localparam logic [BYTE_W-1:0] TGT_ADDR = 8'h00;
  localparam logic [BYTE_W-1:0] SEL_CTRL = 8'h80;
  localparam logic [BYTE_W-1:0] SEL_NV   = 8'h00;

  typedef enum logic [2:0] {
    P_IDLE, P_DEVADDR, P_REGADDR, P_SEL, P_WDATA, P_RDATA, P_SKIP
  } phase_t;

  typedef enum logic {TGT_CTRL = 1'b0, TGT_NV = 1'b1} tgt_t;
endpackage

// File: rtl/i2crs_bus_cond.sv
module i2crs_bus_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_ff[SYNC_STAGES-1];
      sda_p  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  // R4: start and stop conditions are mutually exclusive
  a_r4_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_start && bus_stop));
endmodule

// File: rtl/i2crs_decode.sv
module i2crs_decode
  import i2crs_pkg::*;
(
  input  phase_t            phase,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [1:0]        strap,
  input  logic              wr_ready,
  output logic              ack,
  output phase_t            nxt,
  output logic              sel_we,
  output tgt_t              sel_val,
  output logic              wr_fire
);
  logic addr_hit;
  assign addr_hit = (rx_byte[7:3] == DEV_TYPE) && (rx_byte[2:1] == strap);

  always_comb begin
    ack     = 1'b0;
    nxt     = P_SKIP;
    sel_we  = 1'b0;
    sel_val = TGT_CTRL;
    wr_fire = 1'b0;
    unique case (phase)
      P_DEVADDR: begin
        ack = addr_hit;
        nxt = rx_byte[0] ? P_RDATA : P_REGADDR;
      end
      P_REGADDR: begin
        if (rx_byte == AR_ADDR) begin
          ack = 1'b1;
          nxt = P_SEL;
        end else if (rx_byte == TGT_ADDR) begin
          ack = 1'b1;
          nxt = P_WDATA;
        end
      end
      P_SEL: begin
        if (rx_byte == SEL_CTRL) begin
          ack = 1'b1; sel_we = 1'b1; sel_val = TGT_CTRL;
        end else if (rx_byte == SEL_NV) begin
          ack = 1'b1; sel_we = 1'b1; sel_val = TGT_NV;
        end
      end
      P_WDATA: begin
        wr_fire = 1'b1;
        ack     = wr_ready;
        nxt     = P_WDATA;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2crs_link.sv
module i2crs_link
  import i2crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [1:0]        strap,
  input  logic              wr_ready,
  input  logic [BYTE_W-1:0] ctl_rd,
  input  logic [BYTE_W-1:0] nv_rd,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic              wr_target,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(BYTE_W + 1);

  phase_t            phase, nxt_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rsh, tsh;
  logic              mnak, oe_q;
  tgt_t              sel_q;

  logic              rx_phase, byte_done;
  logic [BYTE_W-1:0] rx_byte, rd_byte;
  logic              dec_ack, dec_sel_we, dec_wr_fire;
  phase_t            dec_nxt;
  tgt_t              dec_sel;

  assign rx_phase  = (phase == P_DEVADDR) || (phase == P_REGADDR) ||
                     (phase == P_SEL)     || (phase == P_WDATA);
  assign rx_byte   = {rsh[BYTE_W-2:0], sda_s};
  assign byte_done = rx_phase && scl_rise && (cnt == C_LAST);
  assign rd_byte   = (sel_q == TGT_CTRL) ? ctl_rd : nv_rd;

  i2crs_decode u_decode (
    .phase    (phase),
    .rx_byte  (rx_byte),
    .strap    (strap),
    .wr_ready (wr_ready),
    .ack      (dec_ack),
    .nxt      (dec_nxt),
    .sel_we   (dec_sel_we),
    .sel_val  (dec_sel),
    .wr_fire  (dec_wr_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      nxt_q <= P_IDLE;
      cnt   <= '0;
      rsh   <= '0;
      tsh   <= '0;
      mnak  <= 1'b1;
      oe_q  <= 1'b0;
      sel_q <= TGT_CTRL;
    end else if (bus_start) begin
      phase <= P_DEVADDR;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (bus_stop) begin
      phase <= P_IDLE;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (rx_phase) begin
      if (scl_rise) begin
        if (cnt <= C_LAST) begin
          rsh <= rx_byte;
          cnt <= cnt + 1'b1;
          if (cnt == C_LAST) begin
            if (dec_ack) nxt_q <= dec_nxt;
            else         phase <= P_SKIP;
            if (dec_sel_we) sel_q <= dec_sel;
          end
        end else if (cnt == C_ACK) begin
          cnt <= C_END;
        end
      end else if (scl_fall) begin
        if (cnt == C_ACK) begin
          oe_q <= 1'b1;
        end else if (cnt == C_END) begin
          oe_q  <= 1'b0;
          cnt   <= '0;
          phase <= nxt_q;
          if (nxt_q == P_RDATA) begin
            tsh  <= rd_byte;
            oe_q <= ~rd_byte[BYTE_W-1];
          end
        end
      end
    end else if (phase == P_RDATA) begin
      if (scl_rise) begin
        if (cnt <= C_LAST) begin
          cnt <= cnt + 1'b1;
        end else if (cnt == C_ACK) begin
          mnak <= sda_s;
          cnt  <= C_END;
        end
      end else if (scl_fall) begin
        if ((cnt != '0) && (cnt <= C_LAST)) begin
          tsh  <= {tsh[BYTE_W-2:0], 1'b0};
          oe_q <= ~tsh[BYTE_W-2];
        end else if (cnt == C_ACK) begin
          oe_q <= 1'b0;
        end else if (cnt == C_END) begin
          cnt <= '0;
          if (!mnak) begin
            tsh  <= rd_byte;
            oe_q <= ~rd_byte[BYTE_W-1];
          end else begin
            phase <= P_SKIP;
          end
        end
      end
    end
  end

  assign sda_oe    = oe_q;
  assign wr_valid  = byte_done && dec_wr_fire;
  assign wr_target = sel_q;
  assign wr_data   = rx_byte;

  // R9: SDA is never newly pulled low while SCL stays high
  a_r9_no_pull_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> !$rose(oe_q));
  // R3: an unmatched address byte sends the link to the ignore phase
  a_r3_mismatch_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == P_DEVADDR &&
     !(rx_byte[7:3] == DEV_TYPE && rx_byte[2:1] == strap)) |=> (phase == P_SKIP));
  // R3, R8: while ignoring, nothing is driven and nothing is written
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_SKIP) |-> (!oe_q && !wr_valid));
  // R4: start restarts at the address byte, stop goes idle
  a_r4_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (phase == P_DEVADDR && cnt == '0));
  a_r4_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (phase == P_IDLE));
  // R6: the selection moves only on a select-code byte
  a_r6_sel_only_from_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> ($past(phase) == P_SEL));
  // R7: a write strobe only arises in the data phase of a write
  a_r7_strobe_in_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (phase == P_WDATA && scl_rise));
  // R2: the bit counter stays within a byte plus its acknowledge slot
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= C_END);
endmodule

// File: rtl/i2c_regsel_slave.sv
module i2c_regsel_slave
  import i2crs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [1:0]        strap_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_target,
  output logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] ctl_rd_i,
  input  logic [BYTE_W-1:0] nv_rd_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2crs_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2crs_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .strap     (strap_i),
    .wr_ready  (wr_ready),
    .ctl_rd    (ctl_rd_i),
    .nv_rd     (nv_rd_i),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_target (wr_target),
    .wr_data   (wr_data)
  );

  assign sda_o = 1'b0;

  // R1: the bus is released while reset is held
  a_r1_reset_release: assert property (@(posedge clk) !rst_n |-> !sda_oe);
endmodule

// File: tb/i2c_regsel_slave_tb.sv
module i2c_regsel_slave_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic [1:0] strap = 2'b10;
  logic wr_ready = 1'b1;
  logic [7:0] ctl_reg, nv_reg;
  logic sda_bus, sda_o, sda_oe, wr_valid, wr_target;
  logic [7:0] wr_data;

  int n_checks = 0, n_err = 0, strobes = 0, r9_bad = 0;
  bit done = 0;
  logic [7:0] exp_ctl = 8'hC3, exp_nv = 8'h5A;
  bit m_sel = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  i2c_regsel_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(strap),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_target(wr_target),
    .wr_data(wr_data), .ctl_rd_i(ctl_reg), .nv_rd_i(nv_reg)
  );

  // Target registers held by the bench, written through the strobe port
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_reg <= 8'hC3;
      nv_reg  <= 8'h5A;
    end else if (wr_valid) begin
      strobes <= strobes + 1;
      if (wr_ready) begin
        if (wr_target) nv_reg <= wr_data;
        else           ctl_reg <= wr_data;
      end
    end
  end

  // R9 monitor: no new pull-down while SCL was and stays high
  always @(posedge clk) begin
    if (rst_n && scl && scl_prev && sda_oe && !oe_prev) r9_bad <= r9_bad + 1;
    scl_prev <= scl;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input bit drive, output bit seen);
    m_low = ~drive;
    qwait();
    scl = 1'b1;
    qwait();
    seen = sda_bus;
    qwait();
    scl = 1'b0;
    qwait();
  endtask

  task automatic i2c_start();
    m_low = 1'b0; qwait();
    scl = 1'b1;   qwait();
    m_low = 1'b1; qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; qwait();
    scl = 1'b1;   qwait();
    m_low = 1'b0; qwait();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] st, input bit rd);
    return {5'b01010, st, rd};
  endfunction

  function automatic bit sel_legal(input logic [7:0] v);
    return (v == 8'h80) || (v == 8'h00);
  endfunction

  function automatic logic [7:0] sel_val();
    return m_sel ? exp_nv : exp_ctl;
  endfunction

  task automatic do_select(input logic [7:0] v, input bit extra);
    bit a;
    i2c_start();
    wbyte(addr_byte(strap, 0), a); chk(a, "R2 select addr ack", a, 1);
    wbyte(8'h02, a);               chk(a, "R5 access reg addr ack", a, 1);
    wbyte(v, a);                   chk(a == sel_legal(v), "R6 select code ack", a, sel_legal(v));
    if (sel_legal(v)) m_sel = (v == 8'h00);
    if (extra) begin
      wbyte(8'h55, a);             chk(!a, "R6 byte after select nack", a, 0);
    end
    i2c_stop();
  endtask

  task automatic do_read(input int n);
    bit a;
    logic [7:0] b;
    i2c_start();
    wbyte(addr_byte(strap, 1), a); chk(a, "R2 read addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      chk(b == sel_val(), "R8 read data", b, sel_val());
    end
    qwait();
    chk(!sda_oe, "R8 release after nack", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic do_write(input int n, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [2:0] rdy);
    bit a, refused;
    int s0, exp_s;
    logic [7:0] d;
    refused = 0; exp_s = 0;
    s0 = strobes;
    i2c_start();
    wbyte(addr_byte(strap, 0), a); chk(a, "R2 write addr ack", a, 1);
    wbyte(8'h00, a);               chk(a, "R5 target addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      wr_ready = rdy[i];
      wbyte(d, a);
      wr_ready = 1'b1;
      if (refused) begin
        chk(!a, "R7 ignored after refusal", a, 0);
      end else begin
        exp_s++;
        chk(a == rdy[i], "R7 data ack follows ready", a, rdy[i]);
        if (rdy[i]) begin
          if (m_sel) exp_nv = d; else exp_ctl = d;
        end else refused = 1;
      end
    end
    i2c_stop();
    chk(strobes - s0 == exp_s, "R7 strobe count", strobes - s0, exp_s);
    chk(ctl_reg == exp_ctl, "R7 control register routing", ctl_reg, exp_ctl);
    chk(nv_reg == exp_nv, "R7 data register routing", nv_reg, exp_nv);
  endtask

  task automatic do_foreign(input logic [7:0] ab);
    bit a;
    int s0;
    s0 = strobes;
    i2c_start();
    wbyte(ab, a);    chk(!a, "R3 foreign address nack", a, 0);
    wbyte(8'h00, a); chk(!a, "R3 ignored byte 1", a, 0);
    wbyte(8'hA7, a); chk(!a, "R3 ignored byte 2", a, 0);
    i2c_stop();
    chk(strobes == s0, "R3 no strobe when ignored", strobes - s0, 0);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_sim();
    end
  end

  initial begin
    bit a, s;
    logic [7:0] b;
    int op, n;
    logic [7:0] v;
    void'($urandom(32'd1234));

    repeat (4) @(negedge clk);
    chk(!sda_oe, "R1 sda released in reset", sda_oe, 0);
    chk(!wr_valid, "R1 no strobe in reset", wr_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sda_oe && !sda_o, "R1 sda released after reset", sda_oe, 0);

    // R1: default selection is the control register
    do_read(1);
    // R6: select data register, extra byte refused
    do_select(8'h00, 1);
    do_read(1);
    // R7, R8: write then multi-byte read
    do_write(2, 8'h3C, 8'h99, 8'h00, 3'b011);
    do_read(3);
    // R7: back-pressure refuses the byte and ignores the rest
    do_write(2, 8'h11, 8'h22, 8'h00, 3'b010);
    do_read(1);
    // R3: strap mismatch and device-type mismatch
    do_foreign(addr_byte(strap ^ 2'b01, 0));
    do_foreign({5'b01011, strap, 1'b0});
    // R5: unknown register address
    i2c_start();
    wbyte(addr_byte(strap, 0), a); chk(a, "R2 addr ack", a, 1);
    wbyte(8'h05, a);               chk(!a, "R5 unknown register nack", a, 0);
    i2c_stop();
    // R6: illegal select code keeps selection
    do_select(8'h40, 0);
    do_read(1);
    // R4: repeated start in the middle of a byte
    i2c_start();
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    i2c_start();
    wbyte(addr_byte(strap, 0), a); chk(a, "R4 restart mid-byte ack", a, 1);
    wbyte(8'h02, a);               chk(a, "R4 restart then reg addr", a, 1);
    wbyte(8'h80, a);               chk(a, "R4 restart then select", a, 1);
    m_sel = 0;
    i2c_stop();
    do_read(1);
    // R4: stop right after the address byte, then a fresh read
    i2c_start();
    wbyte(addr_byte(strap, 0), a); chk(a, "R4 addr before stop", a, 1);
    i2c_stop();
    do_read(1);
    // R8: read right after addressing the access register
    do_select(8'h00, 0);
    i2c_start();
    wbyte(addr_byte(strap, 0), a); chk(a, "R8 addr ack", a, 1);
    wbyte(8'h02, a);               chk(a, "R8 access reg addressed", a, 1);
    i2c_start();
    wbyte(addr_byte(strap, 1), a); chk(a, "R8 repeated start read ack", a, 1);
    rbyte(0, b);
    chk(b == exp_nv, "R8 read is target not access reg", b, exp_nv);
    i2c_stop();
    // R2: other strap setting
    strap = 2'b01;
    repeat (4) @(negedge clk);
    do_read(1);

    // Random mix
    for (int k = 0; k < 36; k++) begin
      op = $urandom % 4;
      case (op)
        0: begin
          v = ($urandom % 3 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h80 : 8'h00);
          do_select(v, 0);
        end
        1: begin
          n = 1 + $urandom % 3;
          do_write(n, 8'($urandom), 8'($urandom), 8'($urandom),
                   {($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0});
        end
        2: do_read(1 + $urandom % 3);
        default: begin
          if ($urandom % 2) do_foreign(addr_byte(strap ^ 2'(1 + $urandom % 3), $urandom % 2));
          else              do_foreign({5'b11010 ^ 5'(1 << ($urandom % 5)) ^ 5'b10000, strap, 1'b0});
        end
      endcase
    end

    chk(r9_bad == 0, "R9 no pull-down while SCL high", r9_bad, 0);
    done = 1;
    finish_sim();
  end
endmodule